// File: doc/BRIEF.md
# Eight-Line Serial Transmit Controller with Indirect Register Window

This block is the host-facing transmit half of an eight-line serial multiplexer. The host sees two registers. The first is a control/status word. It chooses one line and one page of per-line registers, holds the transmit interrupt enable, and reports finished lines. The second is a shared 16-bit window onto the chosen page. Through the window the host loads characters into that line's 32-entry transmit FIFO, reads the FIFO fill count and the line's modem input status, and sets the line's control bits and modem output levels.

Every line whose transmit enable is set and whose FIFO holds data asks for the one shared character port. A round-robin arbiter serves those lines, and each accepted valid/ready handshake moves one character. A line reaches "done" when its FIFO drains through transmission or is discarded by the flush control bit. A done line's number goes into a completion queue. The queue holds at most one entry per line. The host reads the control/status word repeatedly: each read shows the oldest finished line and removes it, and the done flag stays up while entries remain.

The transmit-address and transmit-count pages are not built. They read as zero and ignore writes.

Top module: `octal_tx_hub`

## Requirements
- R1: After reset the control/status word reads 0. A control/status write takes the whole word: bit 14 (interrupt enable) and bits 4:0 (select, with bits 4:3 the page and bits 2:0 the line) read back as written. Bit 13 (memory error) and bit 5 (master reset) always read 0. Bits 10:8 read 0 while the completion queue is empty.
- R2: With page 0 selected, a window write with the low byte enable pushes wdata[7:0] into the selected line's FIFO. A window read returns the fill count in bits 7:0. Bits 15:10 return that line's 6-bit field of mdm_in (line n at bits 6n+5:6n). Bits 9:8 read 0.
- R3: Each FIFO holds 32 characters. A push into a full FIFO is dropped and the count stays 32.
- R4: With page 1 selected, the window low byte bits 5:0 hold the line controls: bit 0 transmit enable, bit 1 auto flow flag (stored only), bit 2 receive enable (stored only), bit 3 break, bit 4 flush, bit 5 modem interrupt enable (stored only). The high byte bits 12:8 hold the modem outputs, which drive mdm_out[5n+4:5n]. Each byte is written only when its enable is set. The break bit drives brk_out[n].
- R5: A line with transmit enable set and a non-empty FIFO presents its oldest character on tx_data and its number on tx_line with tx_valid high. Each cycle with tx_valid and tx_ready removes exactly that character.
- R6: Requesting lines are served round-robin. The search starts at the line after the last one served, and that pointer starts at line 0 after reset or master reset.
- R7: Clearing transmit enable stops the line with its FIFO contents kept. Setting it again resumes with the next unsent character.
- R8: Writing the flush bit empties the line's FIFO in the next cycle. The bit then clears itself, and the line is queued as done.
- R9: A line is queued as done when a transmit handshake empties its FIFO. A line that is already pending is not queued again.
- R10: The done flag (bit 15) is set while the queue holds entries, and bits 10:8 then show the oldest entry. Each control/status read removes that entry, so lines are reported in completion order.
- R11: tx_irq is high exactly when the done flag and the interrupt enable are both set.
- R12: Pages 2 and 3 read as 0, and writes to them change no state.
- R13: A control/status write with bit 5 set clears all FIFOs, line controls, modem outputs, the completion queue, the arbiter pointer and the control/status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the control/status word, 1 selects the indirect window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a control/status read removes the shown completion) |
| bus_be | input | 2 | Byte enables for window writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| tx_valid | output | 1 | A character is offered |
| tx_ready | input | 1 | Transmitter accepts the offered character |
| tx_data | output | 8 | Offered character |
| tx_line | output | 3 | Line the character belongs to |
| tx_irq | output | 1 | Transmit-done interrupt request |
| brk_out | output | 8 | Per-line break (spacing) force |
| mdm_out | output | 40 | Per-line modem outputs, 5 bits per line |
| mdm_in | input | 48 | Per-line modem input status, 6 bits per line |

## Verification
Directed sequences fill a single line to the limit and past it. They pause it in the middle of a drain and resume it, which checks that characters are neither lost nor sent twice. They flush a loaded line, which checks that the flush discards data and still reports a completion. Random rounds then load random subsets of lines with random character counts and drain them together. Those rounds check the round-robin line order and per-line character order, which a single active line cannot test. The completion order read back from the control/status word is compared against the order in which lines emptied, so a queue that loses, repeats or reorders entries is caught. Page 2 and 3 accesses and a master reset are checked through the readable window, the counts and the outputs.

// File: rtl/octal_tx_pkg.sv
package octal_tx_pkg;
    typedef enum logic [1:0] {
        PG_BUF  = 2'd0,
        PG_CTRL = 2'd1,
        PG_ADDR = 2'd2,
        PG_CNT  = 2'd3
    } page_e;

    localparam int CB_TXEN  = 0;
    localparam int CB_AUTO  = 1;
    localparam int CB_RXEN  = 2;
    localparam int CB_BRK   = 3;
    localparam int CB_FLUSH = 4;
    localparam int CB_MIE   = 5;
    localparam int CTRL_W   = 6;
    localparam int MOUT_W   = 5;
    localparam int MIN_W    = 6;
endpackage

// File: rtl/otx_fifo_bank.sv
module otx_fifo_bank #(
    parameter int LINES = 8,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LINES-1:0]           push,
    input  logic [7:0]                 push_data,
    input  logic [LINES-1:0]           pop,
    input  logic [LINES-1:0]           clear,
    output logic [LINES-1:0][CW-1:0]   cnt,
    output logic [LINES-1:0][7:0]      head
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        typedef struct packed {
            logic [AW-1:0] wp;
            logic [AW-1:0] rp;
            logic [CW-1:0] cnt;
        } ptr_t;

        ptr_t       s_d, s_q;
        logic [7:0] mem [DEPTH];
        logic       do_push, do_pop;

        assign do_push = push[g] && (s_q.cnt != CW'(DEPTH)) && !clear[g];
        assign do_pop  = pop[g] && (s_q.cnt != '0) && !clear[g];

        always_comb begin
            s_d = s_q;
            if (clear[g]) begin
                s_d = '0;
            end else begin
                if (do_push) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
                if (do_pop)  s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
                s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        always_ff @(posedge clk) begin
            if (do_push) mem[s_q.wp] <= push_data;
        end

        assign cnt[g]  = s_q.cnt;
        assign head[g] = mem[s_q.rp];

        // R3
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cnt <= CW'(DEPTH));
    end
endmodule

// File: rtl/otx_rr_arb.sv
module otx_rr_arb #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LINES-1:0] req,
    input  logic             adv,
    output logic             gnt_vld,
    output logic [LW-1:0]    gnt_idx
);
    logic [LW-1:0] last_d, last_q;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= LINES; k++) begin
            logic [LW-1:0] idx;
            idx = LW'((int'(last_q) + k) % LINES);
            if (!gnt_vld && req[idx]) begin
                gnt_vld = 1'b1;
                gnt_idx = idx;
            end
        end
        last_d = last_q;
        if (clr)                last_d = '0;
        else if (adv && gnt_vld) last_d = gnt_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= last_d;
    end

    // R6
    grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]);
endmodule

// File: rtl/otx_done_q.sv
module otx_done_q #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES),
    localparam int NW = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_a,
    input  logic [LW-1:0] line_a,
    input  logic          push_b,
    input  logic [LW-1:0] line_b,
    input  logic          pop,
    output logic          not_empty,
    output logic [LW-1:0] head_line
);
    typedef struct packed {
        logic [LINES-1:0][LW-1:0] ent;
        logic [LW-1:0]            wp;
        logic [LW-1:0]            rp;
        logic [NW-1:0]            cnt;
        logic [LINES-1:0]         pend;
    } dq_t;

    dq_t s_d, s_q;

    function automatic logic [LW-1:0] wrap_inc(input logic [LW-1:0] p);
        return (p == LW'(LINES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (pop && s_q.cnt != '0) begin
            s_d.pend[s_q.ent[s_q.rp]] = 1'b0;
            s_d.rp  = wrap_inc(s_q.rp);
            s_d.cnt = s_d.cnt - 1'b1;
        end
        if (push_a && !s_d.pend[line_a]) begin
            s_d.ent[s_d.wp]   = line_a;
            s_d.wp            = wrap_inc(s_d.wp);
            s_d.cnt           = s_d.cnt + 1'b1;
            s_d.pend[line_a]  = 1'b1;
        end
        if (push_b && !s_d.pend[line_b]) begin
            s_d.ent[s_d.wp]   = line_b;
            s_d.wp            = wrap_inc(s_d.wp);
            s_d.cnt           = s_d.cnt + 1'b1;
            s_d.pend[line_b]  = 1'b1;
        end
        if (clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign not_empty = (s_q.cnt != '0);
    assign head_line = not_empty ? s_q.ent[s_q.rp] : '0;

    // R9
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= NW'(LINES));

    // R9
    head_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> s_q.pend[s_q.ent[s_q.rp]]);

    // R10
    count_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        NW'($countones(s_q.pend)) == s_q.cnt);
endmodule

// File: rtl/octal_tx_hub.sv
module octal_tx_hub
    import octal_tx_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DEPTH = 32,
    localparam int LW = $clog2(LINES),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [1:0]                bus_be,
    input  logic [15:0]               bus_wdata,
    output logic [15:0]               bus_rdata,
    output logic                      tx_valid,
    input  logic                      tx_ready,
    output logic [7:0]                tx_data,
    output logic [2:0]                tx_line,
    output logic                      tx_irq,
    output logic [LINES-1:0]          brk_out,
    output logic [LINES*MOUT_W-1:0]   mdm_out,
    input  logic [LINES*MIN_W-1:0]    mdm_in
);
    typedef struct packed {
        logic                            tie;
        logic [4:0]                      sel;
        logic [LINES-1:0][CTRL_W-1:0]    ctrl;
        logic [LINES-1:0][MOUT_W-1:0]    mout;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                       csr_wr, win_wr, csr_rd, mrst;
    page_e                      page;
    logic [LW-1:0]              cur;
    logic [LINES-1:0]           f_push, f_pop, f_clear, req;
    logic [LINES-1:0][CW-1:0]   f_cnt;
    logic [LINES-1:0][7:0]      f_head;
    logic                       gnt_vld, adv;
    logic [LW-1:0]              gnt_idx;
    logic                       q_ne;
    logic [LW-1:0]              q_head;
    logic                       drain_done, fl_vld;
    logic [LW-1:0]              fl_line;

    assign csr_wr = bus_wr && !bus_addr;
    assign win_wr = bus_wr && bus_addr;
    assign csr_rd = bus_rd && !bus_addr;
    assign mrst   = csr_wr && bus_wdata[5];
    assign page   = page_e'(regs_q.sel[4:3]);
    assign cur    = regs_q.sel[LW-1:0];
    assign adv    = gnt_vld && tx_ready;

    always_comb begin
        fl_vld  = 1'b0;
        fl_line = '0;
        for (int i = 0; i < LINES; i++) begin
            f_push[i]  = win_wr && bus_be[0] && (page == PG_BUF) && (cur == LW'(i)) && !mrst;
            f_pop[i]   = adv && (gnt_idx == LW'(i));
            f_clear[i] = regs_q.ctrl[i][CB_FLUSH] || mrst;
            req[i]     = regs_q.ctrl[i][CB_TXEN] && !regs_q.ctrl[i][CB_FLUSH] && (f_cnt[i] != '0);
            if (regs_q.ctrl[i][CB_FLUSH] && !fl_vld) begin
                fl_vld  = 1'b1;
                fl_line = LW'(i);
            end
        end
        drain_done = adv && (f_cnt[gnt_idx] == CW'(1)) && !f_push[gnt_idx];
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < LINES; i++) begin
            if (regs_q.ctrl[i][CB_FLUSH]) regs_d.ctrl[i][CB_FLUSH] = 1'b0;
        end
        if (csr_wr) begin
            regs_d.tie = bus_wdata[14];
            regs_d.sel = bus_wdata[4:0];
        end
        if (win_wr && page == PG_CTRL) begin
            if (bus_be[0]) regs_d.ctrl[cur] = bus_wdata[CTRL_W-1:0];
            if (bus_be[1]) regs_d.mout[cur] = bus_wdata[8 +: MOUT_W];
        end
        if (mrst) regs_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    otx_fifo_bank #(.LINES(LINES), .DEPTH(DEPTH)) u_fifos (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push),
        .push_data (bus_wdata[7:0]),
        .pop       (f_pop),
        .clear     (f_clear),
        .cnt       (f_cnt),
        .head      (f_head)
    );

    otx_rr_arb #(.LINES(LINES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mrst),
        .req     (req),
        .adv     (adv),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    otx_done_q #(.LINES(LINES)) u_doneq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mrst),
        .push_a    (drain_done),
        .line_a    (gnt_idx),
        .push_b    (fl_vld),
        .line_b    (fl_line),
        .pop       (csr_rd),
        .not_empty (q_ne),
        .head_line (q_head)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[15]   = q_ne;
            bus_rdata[14]   = regs_q.tie;
            bus_rdata[10:8] = 3'(q_head);
            bus_rdata[4:0]  = regs_q.sel;
        end else begin
            unique case (page)
                PG_BUF: begin
                    bus_rdata[7:0]   = 8'(f_cnt[cur]);
                    bus_rdata[15:10] = mdm_in[int'(cur)*MIN_W +: MIN_W];
                end
                PG_CTRL: begin
                    bus_rdata[CTRL_W-1:0]  = regs_q.ctrl[cur];
                    bus_rdata[8 +: MOUT_W] = regs_q.mout[cur];
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign tx_valid = gnt_vld;
    assign tx_data  = f_head[gnt_idx];
    assign tx_line  = 3'(gnt_idx);
    assign tx_irq   = q_ne && regs_q.tie;

    for (genvar g = 0; g < LINES; g++) begin : g_out
        assign brk_out[g]                  = regs_q.ctrl[g][CB_BRK];
        assign mdm_out[g*MOUT_W +: MOUT_W] = regs_q.mout[g];

        // R8
        flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q.ctrl[g][CB_FLUSH] |=> (f_cnt[g] == '0));

        // R7
        paused_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!regs_q.ctrl[g][CB_TXEN] && !f_clear[g] && !f_push[g]) |=> $stable(f_cnt[g]));
    end
endmodule

// File: tb/octal_tx_hub_test.sv
module octal_tx_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tx_valid, tx_ready = 1'b0, tx_irq;
    logic [7:0]  tx_data;
    logic [2:0]  tx_line;
    logic [7:0]  brk_out;
    logic [39:0] mdm_out;
    logic [47:0] mdm_in = '0;

    int n_chk = 0, n_err = 0;
    byte unsigned mq [8][$];
    int           exp_done [$];
    logic [7:0]   te_m = '0, pend_m = '0;
    int           last_m = 0;
    logic         tie_b = 1'b0;

    always #5 clk = ~clk;

    octal_tx_hub uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_line(tx_line),
        .tx_irq(tx_irq), .brk_out(brk_out), .mdm_out(mdm_out), .mdm_in(mdm_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int rr_pick(input int last, input logic [7:0] rq);
        for (int k = 1; k <= 8; k++) begin
            if (rq[(last + k) % 8]) return (last + k) % 8;
        end
        return -1;
    endfunction

    task automatic csr_write(input logic [15:0] v);
        @(negedge clk);
        bus_addr = 1'b0; bus_wr = 1'b1; bus_be = 2'b11; bus_wdata = v;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic win_write(input logic [1:0] be, input logic [15:0] v);
        @(negedge clk);
        bus_addr = 1'b1; bus_wr = 1'b1; bus_be = be; bus_wdata = v;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic csr_read(output logic [15:0] v);
        @(negedge clk);
        bus_addr = 1'b0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
        if (v[15]) pend_m[v[10:8]] = 1'b0;
    endtask

    task automatic win_read(output logic [15:0] v);
        @(negedge clk);
        bus_addr = 1'b1; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic select(input int pg, input int ln);
        csr_write({1'b0, tie_b, 9'd0, 2'(pg), 3'(ln)});
    endtask

    task automatic push_char(input int ln, input byte unsigned c);
        win_write(2'b01, {8'h00, c});
        if (mq[ln].size() < 32) mq[ln].push_back(c);
    endtask

    task automatic set_ctrl(input int ln, input logic [5:0] c);
        select(1, ln);
        win_write(2'b01, {10'd0, c});
        te_m[ln] = c[0];
    endtask

    task automatic drain_done_check(input string tag);
        logic [15:0] v;
        while (exp_done.size() > 0) begin
            int e;
            e = exp_done.pop_front();
            csr_read(v);
            chk({tag, " done flag"}, 32'(v[15]), 32'd1);
            chk({tag, " done line"}, 32'(v[10:8]), 32'(e));
        end
        csr_read(v);
        chk({tag, " queue empty"}, 32'(v[15]), 32'd0);
    endtask

    task automatic wait_drained;
        int guard;
        guard = 0;
        while (guard < 3000) begin
            int tot;
            tot = 0;
            for (int l = 0; l < 8; l++) if (te_m[l]) tot += mq[l].size();
            if (tot == 0) break;
            @(posedge clk);
            guard++;
        end
        repeat (2) @(posedge clk);
    endtask

    // Transmit monitor: R5 data order, R6 line order, R9 completion model
    always @(negedge clk) begin
        #2;
        if (rst_n && tx_valid && tx_ready) begin
            logic [7:0] rq;
            int el;
            for (int l = 0; l < 8; l++) rq[l] = te_m[l] && (mq[l].size() > 0);
            el = rr_pick(last_m, rq);
            chk("R6 round-robin line", 32'(tx_line), 32'(el));
            if (mq[tx_line].size() == 0) begin
                chk("R5 unexpected character", 32'(tx_data), 32'hFFFF);
            end else begin
                chk("R5 character order", 32'(tx_data), 32'(mq[tx_line][0]));
                void'(mq[tx_line].pop_front());
                if (mq[tx_line].size() == 0 && !pend_m[tx_line]) begin
                    exp_done.push_back(int'(tx_line));
                    pend_m[tx_line] = 1'b1;
                end
            end
            last_m = int'(tx_line);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R13 reset state
        csr_read(v);
        chk("R1 reset csr", 32'(v), 32'h0000);
        chk("R11 reset irq", 32'(tx_irq), 32'd0);
        chk("R5 reset tx_valid", 32'(tx_valid), 32'd0);

        // R1 readback of enable and select, memory error/reset/line bits read 0
        csr_write(16'h670A);
        csr_read(v);
        chk("R1 csr readback", 32'(v), 32'h400A);
        csr_write(16'h0000);

        // R2 push and count, modem status byte
        mdm_in = 48'h0;
        mdm_in[2*6 +: 6] = 6'b101101;
        select(0, 2);
        for (int i = 0; i < 5; i++) push_char(2, byte'(8'h30 + i));
        win_read(v);
        chk("R2 fill count", 32'(v[7:0]), 32'd5);
        chk("R2 modem status", 32'(v[15:8]), 32'hB4);

        // R3 fill to 32 and overflow
        for (int i = 5; i < 33; i++) push_char(2, byte'($urandom_range(255)));
        win_read(v);
        chk("R3 full count", 32'(v[7:0]), 32'd32);

        // R4 line control and modem outputs
        select(1, 2);
        win_write(2'b11, 16'h150C);
        win_read(v);
        chk("R4 ctrl readback", 32'(v), 32'h150C);
        chk("R4 break output", 32'(brk_out), 32'h04);
        chk("R4 modem output", 32'(mdm_out[14:10]), 32'h15);
        win_write(2'b10, 16'h0AFF);
        win_read(v);
        chk("R4 high byte only", 32'(v), 32'h0A0C);
        win_write(2'b11, 16'h0000);

        // R12 unimplemented pages
        select(2, 2);
        win_write(2'b11, 16'hFFFF);
        win_read(v);
        chk("R12 page 2 reads 0", 32'(v), 32'h0);
        select(3, 2);
        win_write(2'b11, 16'hFFFF);
        win_read(v);
        chk("R12 page 3 reads 0", 32'(v), 32'h0);
        select(1, 2);
        win_read(v);
        chk("R12 ctrl untouched", 32'(v), 32'h0);
        select(0, 2);
        win_read(v);
        chk("R12 count untouched", 32'(v[7:0]), 32'd32);

        // R5 / R7 drain, pause, resume
        set_ctrl(2, 6'h01);
        @(posedge clk); #1 tx_ready = 1'b1;
        repeat (10) @(posedge clk);
        set_ctrl(2, 6'h00);
        repeat (4) @(posedge clk);
        chk("R7 paused no valid", 32'(tx_valid), 32'd0);
        select(0, 2);
        win_read(v);
        chk("R7 contents kept", 32'(v[7:0]), 32'(mq[2].size()));
        set_ctrl(2, 6'h01);
        wait_drained();
        @(posedge clk); #1 tx_ready = 1'b0;
        tie_b = 1'b1;
        select(0, 2);
        chk("R11 irq raised", 32'(tx_irq), 32'd1);
        drain_done_check("R10 single line");
        chk("R11 irq dropped", 32'(tx_irq), 32'd0);

        // R8 flush
        for (int i = 0; i < 4; i++) push_char(2, byte'(8'hA0 + i));
        select(0, 5);
        for (int i = 0; i < 4; i++) push_char(5, byte'(8'h50 + i));
        select(1, 5);
        win_write(2'b01, 16'h0010);
        mq[5].delete();
        exp_done.push_back(5);
        pend_m[5] = 1'b1;
        @(posedge clk);
        win_read(v);
        chk("R8 flush self-clear", 32'(v[5:0]), 32'h0);
        select(0, 5);
        win_read(v);
        chk("R8 flushed count", 32'(v[7:0]), 32'd0);
        select(0, 2);
        win_read(v);
        chk("R8 other line kept", 32'(v[7:0]), 32'd4);
        drain_done_check("R8 flush done");

        // R6 / R9 / R10 random rounds
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 8; l++) begin
                if ($urandom_range(3) != 0) begin
                    int n;
                    n = $urandom_range(1, 12);
                    select(0, l);
                    for (int i = 0; i < n; i++) push_char(l, byte'($urandom_range(255)));
                end
            end
            for (int l = 0; l < 8; l++) set_ctrl(l, 6'h01);
            @(posedge clk); #1 tx_ready = 1'b1;
            wait_drained();
            @(posedge clk); #1 tx_ready = 1'b0;
            chk("R9 entries at most lines", 32'(exp_done.size() <= 8), 32'd1);
            drain_done_check("R10 random round");
            for (int l = 0; l < 8; l++) set_ctrl(l, 6'h00);
        end

        // R13 master reset
        select(0, 1);
        for (int i = 0; i < 3; i++) push_char(1, byte'(i));
        select(1, 1);
        win_write(2'b11, 16'h1F08);
        csr_write(16'h4020);
        for (int l = 0; l < 8; l++) mq[l].delete();
        te_m = '0; pend_m = '0; last_m = 0; tie_b = 1'b0;
        exp_done.delete();
        csr_read(v);
        chk("R13 csr cleared", 32'(v), 32'h0);
        chk("R13 modem outputs", 32'(mdm_out), 32'h0);
        chk("R13 break outputs", 32'(brk_out), 32'h0);
        select(0, 1);
        win_read(v);
        chk("R13 fifo cleared", 32'(v[7:0]), 32'd0);
        select(1, 1);
        win_read(v);
        chk("R13 ctrl cleared", 32'(v), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule